// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides whether a received frame is kept, judging only by its 48-bit destination address. It looks for a match in four places: one station address, a bank of fifteen extra exact-match entries, and two 256-bucket hash tables indexed by the CRC-32 of the address. One table serves individual (unicast) addresses and the other serves group (multicast) addresses. A broadcast-reject control and separate unicast and multicast promiscuous controls sit on top of the matching.

The MAC's receive path presents each destination address with a one-cycle strobe. The block returns an accept flag and a match-source code a fixed number of cycles later. The match-source code lets downstream logic tell an exact hit from an imperfect hash hit, since a hash hit may still need checking further up. Configuration and table contents are loaded through a simple 32-bit register-write port. The CRC is computed inside the block.

Top module: `rx_addr_filter`

## Requirements
- R1: If `da_valid_i` is high at rising edge n, then `res_valid_o` is high for the one cycle after edge n+2 and carries that address's result. Whenever `res_valid_o` is low, `accept_o` and `match_src_o` are 0.
- R2: The hash index is computed from the address bits in wire order: octet `da[47:40]` goes first, and within each octet the least significant bit goes first. The CRC register starts at 0xFFFFFFFF. For each bit, fb = crc[31] xor bit, then crc = (crc << 1) xor (fb ? 0x04C11DB7 : 0). The bucket is crc[31:24]. Bucket k is bit k[4:0] of table word k[7:5]. A unicast address (bit 40 = 0) looks up the individual table, at words 48..55. In normal mode a multicast address looks up the group table, at words 56..63. A set bucket gives accept with code 3.
- R3: The station address is written as its low 32 bits at word 1 and `da[47:32]` in bits [15:0] of word 2. An equal destination is accepted with code 1. An all-zero station address never matches.
- R4: Control word 0 bit 0 is broadcast reject. When it is set, the all-ones address is rejected with code 6, whatever else matches.
- R5: Exact entry e (0..14) is written as its low 32 bits at word 16+2e and as `da[47:32]` plus an enable flag in bit 16 at word 17+2e. An equal destination is accepted with code 2 only if the entry is enabled and nonzero.
- R6: The all-ones address is accepted with code 4 when broadcast reject is clear and neither the station nor an exact entry matches.
- R7: Control bit 1 (unicast promiscuous) accepts, with code 5, a unicast address that has no other match. It has no effect on multicast addresses.
- R8: Control bit 2 (multicast promiscuous) accepts, with code 5, a multicast address that has no other match. It has no effect on unicast addresses.
- R9: Control bit 3 selects extended group hashing. Multicast addresses then use crc[31:23] as a 9-bit index: bit 8 = 0 picks the individual table and bit 8 = 1 picks the group table, each at bucket index[7:0]. Unicast lookups are unchanged.
- R10: Writing control word 0 with bit 4 set zeroes both hash tables in one cycle. The station address and the exact entries keep their values.
- R11: The match sources are ranked in this order: broadcast reject, station, exact entry, broadcast, hash, promiscuous. An address that matches none of them is rejected with code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| da_valid_i | input | 1 | Destination address strobe |
| da_i | input | 48 | Destination address; bits [47:40] are the first octet on the wire |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 6 | Register word address |
| cfg_wdata_i | input | 32 | Register write data |
| res_valid_o | output | 1 | Result strobe |
| accept_o | output | 1 | Frame accepted |
| match_src_o | output | 3 | Match source code |

## Verification
On every cycle, the assertions check three things: the fixed strobe-to-result latency, that outputs are quiet outside a result, and that the match-source codes agree with the accept flag. In particular, a broadcast-reject or broadcast code may appear only when the address three cycles back was all ones. Whether a given address lands in the right bucket, and whether the ranking and the promiscuous and extended-hash modes are correct, can be shown only by the bench. The bench sweeps every combination of the four control bits over station, exact-entry, broadcast, zero and random addresses. It also checks that a hash clear leaves the exact entries intact.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned DA_W   = 48;
  localparam int unsigned REG_AW = 6;
  localparam int unsigned GRP_BIT = 40;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

  localparam int unsigned REG_CTRL       = 0;
  localparam int unsigned REG_STN_LO     = 1;
  localparam int unsigned REG_STN_HI     = 2;
  localparam int unsigned REG_EXACT_BASE = 16;
  localparam int unsigned REG_IHASH_BASE = 48;
  localparam int unsigned REG_GHASH_BASE = 56;
  localparam int unsigned CTRL_CLR_BIT   = 4;
  localparam int unsigned EXACT_EN_BIT   = 16;

  typedef struct packed {
    logic ext_hash;
    logic mc_prom;
    logic uc_prom;
    logic bcast_rej;
  } ctrl_t;

  typedef enum logic [2:0] {
    SRC_NONE    = 3'd0,
    SRC_STATION = 3'd1,
    SRC_EXACT   = 3'd2,
    SRC_HASH    = 3'd3,
    SRC_BCAST   = 3'd4,
    SRC_PROMISC = 3'd5,
    SRC_BREJ    = 3'd6
  } match_src_e;
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int unsigned NUM_EXACT = 15,
  parameter int unsigned HASH_REGS = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [REG_AW-1:0]             addr_i,
  input  logic [31:0]                   wdata_i,
  output ctrl_t                         ctrl_o,
  output logic [DA_W-1:0]               station_o,
  output logic [NUM_EXACT-1:0][DA_W-1:0] exact_addr_o,
  output logic [NUM_EXACT-1:0]          exact_en_o,
  output logic [HASH_REGS*32-1:0]       ihash_o,
  output logic [HASH_REGS*32-1:0]       ghash_o
);
  localparam logic [REG_AW-1:0] A_CTRL   = REG_AW'(REG_CTRL);
  localparam logic [REG_AW-1:0] A_STN_LO = REG_AW'(REG_STN_LO);
  localparam logic [REG_AW-1:0] A_STN_HI = REG_AW'(REG_STN_HI);

  logic hash_clr;
  assign hash_clr = we_i && (addr_i == A_CTRL) && wdata_i[CTRL_CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o    <= '0;
      station_o <= '0;
    end else if (we_i) begin
      if (addr_i == A_CTRL)   ctrl_o <= ctrl_t'(wdata_i[3:0]);
      if (addr_i == A_STN_LO) station_o[31:0] <= wdata_i;
      if (addr_i == A_STN_HI) station_o[DA_W-1:32] <= wdata_i[DA_W-33:0];
    end
  end

  for (genvar e = 0; e < NUM_EXACT; e++) begin : g_exact
    localparam logic [REG_AW-1:0] A_LO = REG_AW'(REG_EXACT_BASE + 2*e);
    localparam logic [REG_AW-1:0] A_HI = REG_AW'(REG_EXACT_BASE + 2*e + 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        exact_addr_o[e] <= '0;
        exact_en_o[e]   <= 1'b0;
      end else if (we_i) begin
        if (addr_i == A_LO) exact_addr_o[e][31:0] <= wdata_i;
        if (addr_i == A_HI) begin
          exact_addr_o[e][DA_W-1:32] <= wdata_i[DA_W-33:0];
          exact_en_o[e]              <= wdata_i[EXACT_EN_BIT];
        end
      end
    end
  end

  for (genvar r = 0; r < HASH_REGS; r++) begin : g_hash
    localparam logic [REG_AW-1:0] A_I = REG_AW'(REG_IHASH_BASE + r);
    localparam logic [REG_AW-1:0] A_G = REG_AW'(REG_GHASH_BASE + r);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ihash_o[32*r +: 32] <= '0;
        ghash_o[32*r +: 32] <= '0;
      end else if (hash_clr) begin
        ihash_o[32*r +: 32] <= '0;
        ghash_o[32*r +: 32] <= '0;
      end else if (we_i) begin
        if (addr_i == A_I) ihash_o[32*r +: 32] <= wdata_i;
        if (addr_i == A_G) ghash_o[32*r +: 32] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/rxf_crc_hash.sv
module rxf_crc_hash
  import rxf_pkg::*;
#(
  parameter int unsigned OUT_W = 9
) (
  input  logic [DA_W-1:0]  da_i,
  output logic [OUT_W-1:0] idx_o
);
  logic [31:0] crc;
  logic        fb;

  // Wire order: octet [47:40] first, LSB of each octet first.
  always_comb begin
    crc = '1;
    fb  = 1'b0;
    for (int i = 0; i < int'(DA_W); i++) begin
      fb  = crc[31] ^ da_i[(DA_W-8) - 8*(i/8) + (i%8)];
      crc = {crc[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
    end
    idx_o = crc[31 -: OUT_W];
  end
endmodule

// File: rtl/rxf_exact_match.sv
module rxf_exact_match
  import rxf_pkg::*;
#(
  parameter int unsigned NUM_EXACT = 15
) (
  input  logic [DA_W-1:0]                da_i,
  input  logic [DA_W-1:0]                station_i,
  input  logic [NUM_EXACT-1:0][DA_W-1:0] exact_addr_i,
  input  logic [NUM_EXACT-1:0]           exact_en_i,
  output logic                           stn_hit_o,
  output logic                           exact_hit_o
);
  logic [NUM_EXACT-1:0] hit;

  assign stn_hit_o = (|station_i) && (da_i == station_i);

  for (genvar e = 0; e < NUM_EXACT; e++) begin : g_cmp
    assign hit[e] = exact_en_i[e] && (|exact_addr_i[e]) && (da_i == exact_addr_i[e]);
  end

  assign exact_hit_o = |hit;
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int unsigned NUM_EXACT = 15,
  parameter int unsigned HASH_REGS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              da_valid_i,
  input  logic [DA_W-1:0]   da_i,
  input  logic              cfg_we_i,
  input  logic [REG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic              res_valid_o,
  output logic              accept_o,
  output logic [2:0]        match_src_o
);
  localparam int unsigned HBITS  = HASH_REGS * 32;
  localparam int unsigned HIDX_W = $clog2(HBITS);

  ctrl_t                         ctrl;
  logic [DA_W-1:0]               station;
  logic [NUM_EXACT-1:0][DA_W-1:0] exact_addr;
  logic [NUM_EXACT-1:0]          exact_en;
  logic [HBITS-1:0]              ihash, ghash;

  rxf_cfg_regs #(.NUM_EXACT(NUM_EXACT), .HASH_REGS(HASH_REGS)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .ctrl_o(ctrl), .station_o(station),
    .exact_addr_o(exact_addr), .exact_en_o(exact_en),
    .ihash_o(ihash), .ghash_o(ghash)
  );

  // Stage 1: capture address
  logic            v1;
  logic [DA_W-1:0] da1;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1  <= 1'b0;
      da1 <= '0;
    end else begin
      v1 <= da_valid_i;
      if (da_valid_i) da1 <= da_i;
    end
  end

  logic [HIDX_W:0]   idx;
  logic [HIDX_W-1:0] idx_n;
  logic              stn_hit, ex_hit, hash_hit, grp, bc;

  rxf_crc_hash #(.OUT_W(HIDX_W + 1)) u_crc (.da_i(da1), .idx_o(idx));

  rxf_exact_match #(.NUM_EXACT(NUM_EXACT)) u_cmp (
    .da_i(da1), .station_i(station),
    .exact_addr_i(exact_addr), .exact_en_i(exact_en),
    .stn_hit_o(stn_hit), .exact_hit_o(ex_hit)
  );

  assign idx_n = idx[HIDX_W:1];
  assign grp   = da1[GRP_BIT];
  assign bc    = &da1;

  always_comb begin
    if (!grp)               hash_hit = ihash[idx_n];
    else if (!ctrl.ext_hash) hash_hit = ghash[idx_n];
    else if (idx[HIDX_W])    hash_hit = ghash[idx[HIDX_W-1:0]];
    else                     hash_hit = ihash[idx[HIDX_W-1:0]];
  end

  // Stage 2: match flags
  logic v2, stn2, ex2, hh2, grp2, bc2;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {v2, stn2, ex2, hh2, grp2, bc2} <= '0;
    end else begin
      v2   <= v1;
      stn2 <= v1 && stn_hit;
      ex2  <= v1 && ex_hit;
      hh2  <= v1 && hash_hit;
      grp2 <= v1 && grp;
      bc2  <= v1 && bc;
    end
  end

  // Stage 3: ranked decision
  logic       acc_d;
  match_src_e src_d;
  always_comb begin
    acc_d = 1'b1;
    if (bc2 && ctrl.bcast_rej) begin
      acc_d = 1'b0; src_d = SRC_BREJ;
    end else if (stn2)  src_d = SRC_STATION;
    else if (ex2)       src_d = SRC_EXACT;
    else if (bc2)       src_d = SRC_BCAST;
    else if (hh2)       src_d = SRC_HASH;
    else if (grp2 ? ctrl.mc_prom : ctrl.uc_prom) src_d = SRC_PROMISC;
    else begin
      acc_d = 1'b0; src_d = SRC_NONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      accept_o    <= 1'b0;
      match_src_o <= '0;
    end else begin
      res_valid_o <= v2;
      accept_o    <= v2 && acc_d;
      match_src_o <= v2 ? src_d : SRC_NONE;
    end
  end
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk
  import rxf_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            da_valid_i,
  input logic [DA_W-1:0] da_i,
  input logic            res_valid_o,
  input logic            accept_o,
  input logic [2:0]      match_src_o
);
  logic [2:0] vhist, bchist;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vhist  <= '0;
      bchist <= '0;
    end else begin
      vhist  <= {vhist[1:0], da_valid_i};
      bchist <= {bchist[1:0], da_valid_i && (&da_i)};
    end
  end

  // R1
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o == vhist[2]);

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (!accept_o && match_src_o == 3'd0));

  // R4
  brej_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_src_o == SRC_BREJ) |-> (!accept_o && bchist[2]));

  // R6
  bcast_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_src_o == SRC_BCAST) |-> (accept_o && bchist[2]));

  // R11
  accept_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (match_src_o inside {SRC_STATION, SRC_EXACT, SRC_HASH, SRC_BCAST, SRC_PROMISC}));

  // R11
  reject_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !accept_o) |-> (match_src_o inside {SRC_NONE, SRC_BREJ}));
endmodule

bind rx_addr_filter rx_addr_filter_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .da_valid_i(da_valid_i), .da_i(da_i),
  .res_valid_o(res_valid_o), .accept_o(accept_o), .match_src_o(match_src_o)
);

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NEX = 15;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        da_valid_i = 1'b0;
  logic [47:0] da_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [5:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        res_valid_o, accept_o;
  logic [2:0]  match_src_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter dut_i (
    .clk_i(clk), .rst_ni, .da_valid_i, .da_i,
    .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .res_valid_o, .accept_o, .match_src_o
  );

  int n_chk = 0, n_bad = 0, cyc = 0;

  // shadow configuration
  logic [3:0]  m_ctrl = '0;
  logic [47:0] m_stn = '0;
  logic [47:0] m_ex [NEX];
  logic        m_en [NEX];
  logic [31:0] m_ih [8];
  logic [31:0] m_gh [8];

  function automatic logic [31:0] crc_of(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int o = 0; o < 6; o++) begin
      logic [7:0] b = a[47 - 8*o -: 8];
      for (int k = 0; k < 8; k++) begin
        logic f = c[31] ^ b[k];
        c = (c << 1) ^ (f ? 32'h04C1_1DB7 : 32'h0);
      end
    end
    return c;
  endfunction

  function automatic logic tbl_bit(input logic grp_tbl, input logic [7:0] k);
    return grp_tbl ? m_gh[k[7:5]][k[4:0]] : m_ih[k[7:5]][k[4:0]];
  endfunction

  task automatic model(input logic [47:0] a, output logic acc, output logic [2:0] src,
                       output string tag);
    logic [31:0] c = crc_of(a);
    logic grp = a[40];
    logic bc = (a == 48'hFFFF_FFFF_FFFF);
    logic stn = (m_stn != 0) && (a == m_stn);
    logic ex = 1'b0;
    logic hh;
    for (int e = 0; e < NEX; e++)
      if (m_en[e] && m_ex[e] != 0 && m_ex[e] == a) ex = 1'b1;
    if (!grp)           hh = tbl_bit(1'b0, c[31:24]);
    else if (!m_ctrl[3]) hh = tbl_bit(1'b1, c[31:24]);
    else                 hh = tbl_bit(c[31], c[30:23]);
    acc = 1'b1;
    if (bc && m_ctrl[0]) begin acc = 0; src = 6; tag = "R4"; end
    else if (stn) begin src = 1; tag = "R3"; end
    else if (ex)  begin src = 2; tag = "R5"; end
    else if (bc)  begin src = 4; tag = "R6"; end
    else if (hh)  begin src = 3; tag = (grp && m_ctrl[3]) ? "R9" : "R2"; end
    else if (grp ? m_ctrl[2] : m_ctrl[1]) begin src = 5; tag = grp ? "R8" : "R7"; end
    else begin acc = 0; src = 0; tag = "R11"; end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = 6'(a); cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic set_ctrl(input logic [3:0] c);
    m_ctrl = c;
    wr(0, {28'h0, c});
  endtask

  task automatic lookup(input logic [47:0] a, input string force_tag);
    logic eacc; logic [2:0] esrc; string tag;
    model(a, eacc, esrc, tag);
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    da_i = a; da_valid_i = 1'b1;
    @(negedge clk);
    da_valid_i = 1'b0; da_i = '0;
    @(negedge clk);
    @(negedge clk);
    n_chk++;
    if (res_valid_o !== 1'b1 || accept_o !== eacc || match_src_o !== esrc) begin
      n_bad++;
      $display("FAIL %s da=%h: valid/acc/src = %b/%b/%0d expected 1/%b/%0d",
               tag, a, res_valid_o, accept_o, match_src_o, eacc, esrc);
    end
  endtask

  function automatic logic [47:0] rnd48();
    return {16'($urandom), 32'($urandom)};
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_bad++;
      $display("FAIL watchdog: cycles %0d expected below %0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    logic [47:0] a;
    for (int e = 0; e < NEX; e++) begin m_ex[e] = '0; m_en[e] = 1'b0; end
    for (int r = 0; r < 8; r++) begin m_ih[r] = '0; m_gh[r] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    n_chk++;
    if (res_valid_o !== 1'b0 || accept_o !== 1'b0 || match_src_o !== 3'd0) begin
      n_bad++;
      $display("FAIL R1 reset: %b/%b/%0d expected 0/0/0", res_valid_o, accept_o, match_src_o);
    end
    rst_ni = 1'b1;

    // R11 / R3: nothing configured, zero address must not match zero station
    lookup(48'h0, "R3");
    lookup(48'h0012_3456_789A, "R11");

    // program station, entries, tables
    m_stn = rnd48(); m_stn[40] = 1'b0;
    wr(1, m_stn[31:0]); wr(2, {16'h0, m_stn[47:32]});
    for (int e = 0; e < NEX; e++) begin
      a = rnd48(); a[40] = e[0];
      if (e == 13) a = '0;
      m_ex[e] = a; m_en[e] = (e != 7);
      wr(16 + 2*e, a[31:0]);
      wr(17 + 2*e, {15'h0, m_en[e], a[47:32]});
    end
    for (int r = 0; r < 8; r++) begin
      m_ih[r] = 32'hA5C3_0F96 ^ (32'(r) * 32'h1357_9BDF);
      m_gh[r] = 32'h3C69_E11E ^ (32'(r) * 32'h2468_ACE1);
      wr(48 + r, m_ih[r]);
      wr(56 + r, m_gh[r]);
    end

    // sweep all control combinations
    for (int c = 0; c < 16; c++) begin
      set_ctrl(4'(c));
      for (int j = 0; j < 64; j++) begin
        case (j % 8)
          0: a = m_stn;
          1: a = m_ex[j % NEX];
          2: a = 48'hFFFF_FFFF_FFFF;
          3: a = 48'h0;
          4: begin a = rnd48(); a[40] = 1'b0; end
          5: begin a = rnd48(); a[40] = 1'b1; end
          6: a = m_ex[7];
          default: a = rnd48();
        endcase
        lookup(a, "");
      end
    end

    // R10: clear hash tables, exact state survives
    m_ctrl = 4'b0000;
    wr(0, 32'h0000_0010);
    for (int r = 0; r < 8; r++) begin m_ih[r] = '0; m_gh[r] = '0; end
    lookup(m_stn, "R10");
    for (int e = 0; e < NEX; e++) lookup(m_ex[e], "R10");
    for (int j = 0; j < 32; j++) lookup(rnd48(), "R10");

    finish_run();
  end
endmodule